// File: doc/BRIEF.md
# Outstanding Line-Fetch Tracking Table

This block tracks cache-line fetches that have been sent to memory and have not yet returned. Each entry holds a line address, which is the request address with its low six bits dropped, and a flag that tells whether a prefetch or a demand miss opened it. It also holds the internal cycle count at which the entry was opened. Allocation requests arrive on one port and carry a prefetch or demand tag. The response comes one cycle later. It says whether the request opened a new fetch or joined one already in flight, and it names the class of any duplicate.

A fill pulse reports that the cache now holds a line, and the matching entry is retired. When a demand entry retires, the cycles it waited are added to a waited-cycles accumulator. When a demand miss arrives for a line that a prefetch is already fetching, the entry is converted into a demand entry stamped with the current cycle. The cycles the prefetch had already covered are added to a saved-cycles accumulator. A fill and an allocation in the same cycle are processed fill first. A combinational lookup port lets a client ask whether any line is currently in flight.

Top module: `mshr_table`

## Requirements
- R1: Allocation, fill and lookup addresses are compared on bits [63:6] only, so the low six address bits never change an outcome.
- R2: An allocation whose line matches no entry, while a slot is free, inserts a new entry. On the next cycle the response shows `rsp_valid`=1, `rsp_fresh`=1, `rsp_kind`=0 and `rsp_refused`=0, `occupancy` rises by one, and `lookup_hit` is 1 for that line from then on.
- R3: An allocation whose line matches a valid entry inserts nothing and reports `rsp_fresh`=0.
- R4: A non-matching allocation made while all slots are valid inserts nothing. It reports `rsp_fresh`=1 and `rsp_refused`=1, and `cnt_full` increases by one.
- R5: A prefetch allocation that matches any entry reports `rsp_kind`=1, increases `cnt_pf_dup` by one, and leaves the entry unchanged.
- R6: A demand allocation that matches an entry opened by a prefetch reports `rsp_kind`=2 and increases `cnt_partial` by one. It adds to `acc_saved` the number of clock edges from the opening edge to this edge. The entry then becomes a demand entry stamped at this edge.
- R7: A demand allocation that matches a demand entry reports `rsp_kind`=3 and increases `cnt_overlap` by one.
- R8: A fill whose line matches an entry removes that entry. A demand entry adds to `acc_waited` the clock edges elapsed since it was stamped, and a prefetch entry adds nothing. A fill for an absent line changes nothing.
- R9: When a fill and an allocation occur in the same cycle, the fill is applied first. The slot it frees can take the allocation, and an allocation for the line being filled counts as a fresh miss.
- R10: After reset the table is empty, every counter and accumulator is zero, and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Line-present pulse |
| fill_addr | input | 64 | Address of the line now present |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_pf | input | 1 | 1 = prefetch, 0 = demand miss |
| alloc_addr | input | 64 | Requested address |
| lookup_addr | input | 64 | Address queried for in-flight state |
| lookup_hit | output | 1 | Line of `lookup_addr` is in flight |
| rsp_valid | output | 1 | Response to last cycle's allocation |
| rsp_fresh | output | 1 | Allocation counted as a new miss |
| rsp_kind | output | 2 | 0 miss, 1 prefetch duplicate, 2 partial hit, 3 demand overlap |
| rsp_refused | output | 1 | New miss not recorded, table full |
| occupancy | output | 5 | Number of valid entries |
| cnt_full | output | 32 | Refused allocations |
| cnt_pf_dup | output | 32 | Prefetch duplicates |
| cnt_partial | output | 32 | Demand hits on prefetch entries |
| cnt_overlap | output | 32 | Demand hits on demand entries |
| acc_saved | output | 48 | Summed cycles covered by prefetches |
| acc_waited | output | 48 | Summed demand wait cycles |

## Verification
A corrupted valid bit or stored line shows up one cycle after the next allocation or lookup for that line. It appears as a wrong `rsp_fresh` or `rsp_kind`, an `occupancy` step that is off by one, or a `lookup_hit` that disagrees with the bench's model. A wrong stamp or prefetch flag stays hidden until the entry is either retired by a fill or joined by a demand miss. At that edge `acc_waited` or `acc_saved` differs from the bench's edge-count arithmetic. The bench compares every output after every operation, including a long pseudo-random mix over a pool of lines slightly larger than the table, so any divergence is caught at the first operation that exposes it.

// File: rtl/mshr_pkg.sv
`timescale 1ns/1ps
package mshr_pkg;

  typedef enum logic [1:0] {
    KIND_MISS    = 2'd0,
    KIND_PF_DUP  = 2'd1,
    KIND_PARTIAL = 2'd2,
    KIND_OVERLAP = 2'd3
  } rsp_kind_e;

  // Elapsed edges between two stamps, modulo 2**w.
  function automatic logic [63:0] span(input logic [63:0] later,
                                       input logic [63:0] earlier,
                                       input int unsigned w);
    logic [63:0] m;
    m = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (later - earlier) & m;
  endfunction

  // Classify an allocation from its match outcome.
  function automatic rsp_kind_e classify(input logic hit, input logic req_pf,
                                         input logic ent_pf);
    if (!hit)        return KIND_MISS;
    else if (req_pf) return KIND_PF_DUP;
    else if (ent_pf) return KIND_PARTIAL;
    else             return KIND_OVERLAP;
  endfunction

endpackage

// File: rtl/mshr_cam.sv
`timescale 1ns/1ps
module mshr_cam #(
  parameter int N = 16,
  parameter int W = 58
) (
  input  logic [N-1:0]        vld,
  input  logic [N-1:0][W-1:0] lines,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (lines[g] == key);
  end
endmodule

// File: rtl/mshr_pick.sv
`timescale 1ns/1ps
module mshr_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  free,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |free;
    for (int i = N - 1; i >= 0; i--) begin
      if (free[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mshr_stats.sv
`timescale 1ns/1ps
module mshr_stats #(
  parameter int CNT_W   = 32,
  parameter int ACC_W   = 48,
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_refuse,
  input  logic               ev_pf_dup,
  input  logic               ev_partial,
  input  logic               ev_overlap,
  input  logic               ev_wait,
  input  logic [STAMP_W-1:0] wait_amt,
  input  logic [STAMP_W-1:0] saved_amt,
  output logic [CNT_W-1:0]   cnt_full,
  output logic [CNT_W-1:0]   cnt_pf_dup,
  output logic [CNT_W-1:0]   cnt_partial,
  output logic [CNT_W-1:0]   cnt_overlap,
  output logic [ACC_W-1:0]   acc_saved,
  output logic [ACC_W-1:0]   acc_waited
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_full    <= '0;
      cnt_pf_dup  <= '0;
      cnt_partial <= '0;
      cnt_overlap <= '0;
      acc_saved   <= '0;
      acc_waited  <= '0;
    end else begin
      if (ev_refuse)  cnt_full    <= cnt_full + 1'b1;
      if (ev_pf_dup)  cnt_pf_dup  <= cnt_pf_dup + 1'b1;
      if (ev_overlap) cnt_overlap <= cnt_overlap + 1'b1;
      if (ev_partial) begin
        cnt_partial <= cnt_partial + 1'b1;
        acc_saved   <= acc_saved + ACC_W'(saved_amt);
      end
      if (ev_wait) acc_waited <= acc_waited + ACC_W'(wait_amt);
    end
  end
endmodule

// File: rtl/mshr_table.sv
`timescale 1ns/1ps
module mshr_table #(
  parameter int ADDR_W    = 64,
  parameter int LINE_BITS = 6,
  parameter int ENTRIES   = 16,
  parameter int STAMP_W   = 32,
  parameter int CNT_W     = 32,
  parameter int ACC_W     = 48
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic                         alloc_valid,
  input  logic                         alloc_is_pf,
  input  logic [ADDR_W-1:0]            alloc_addr,
  input  logic [ADDR_W-1:0]            lookup_addr,
  output logic                         lookup_hit,
  output logic                         rsp_valid,
  output logic                         rsp_fresh,
  output logic [1:0]                   rsp_kind,
  output logic                         rsp_refused,
  output logic [$clog2(ENTRIES+1)-1:0] occupancy,
  output logic [CNT_W-1:0]             cnt_full,
  output logic [CNT_W-1:0]             cnt_pf_dup,
  output logic [CNT_W-1:0]             cnt_partial,
  output logic [CNT_W-1:0]             cnt_overlap,
  output logic [ACC_W-1:0]             acc_saved,
  output logic [ACC_W-1:0]             acc_waited
);
  import mshr_pkg::*;

  localparam int LINE_W = ADDR_W - LINE_BITS;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OCC_W  = $clog2(ENTRIES + 1);

  // Entry storage
  logic [ENTRIES-1:0]              ent_vld;
  logic [ENTRIES-1:0]              ent_pf;
  logic [ENTRIES-1:0][LINE_W-1:0]  ent_line;
  logic [ENTRIES-1:0][STAMP_W-1:0] ent_stamp;
  logic [STAMP_W-1:0]              now;

  // Line keys
  logic [LINE_W-1:0] fill_line, alloc_line, look_line;
  logic              unused_low_bits;
  assign fill_line  = fill_addr[ADDR_W-1:LINE_BITS];
  assign alloc_line = alloc_addr[ADDR_W-1:LINE_BITS];
  assign look_line  = lookup_addr[ADDR_W-1:LINE_BITS];
  assign unused_low_bits = ^{fill_addr[LINE_BITS-1:0], alloc_addr[LINE_BITS-1:0],
                             lookup_addr[LINE_BITS-1:0]};

  // Match vectors
  logic [ENTRIES-1:0] fill_hit, alloc_hit_raw, look_hit;

  mshr_cam #(.N(ENTRIES), .W(LINE_W)) u_cam_fill (
    .vld(ent_vld), .lines(ent_line), .key(fill_line), .hit(fill_hit));
  mshr_cam #(.N(ENTRIES), .W(LINE_W)) u_cam_alloc (
    .vld(ent_vld), .lines(ent_line), .key(alloc_line), .hit(alloc_hit_raw));
  mshr_cam #(.N(ENTRIES), .W(LINE_W)) u_cam_look (
    .vld(ent_vld), .lines(ent_line), .key(look_line), .hit(look_hit));

  assign lookup_hit = |look_hit;

  // Fill first, then allocation against the surviving entries
  logic [ENTRIES-1:0] fill_kill, vld_post, alloc_match;
  logic               match_any, match_pf;
  logic [STAMP_W-1:0] match_stamp, wait_stamp;
  logic               wait_dem;

  always_comb begin
    fill_kill   = fill_valid ? fill_hit : '0;
    vld_post    = ent_vld & ~fill_kill;
    alloc_match = alloc_hit_raw & vld_post;
    match_any   = |alloc_match;
    match_pf    = 1'b0;
    match_stamp = '0;
    wait_dem    = 1'b0;
    wait_stamp  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_match[i]) begin
        match_pf    = match_pf | ent_pf[i];
        match_stamp = match_stamp | ent_stamp[i];
      end
      if (fill_kill[i] && !ent_pf[i]) begin
        wait_dem   = 1'b1;
        wait_stamp = wait_stamp | ent_stamp[i];
      end
    end
  end

  // Free-slot selection
  logic [IDX_W-1:0] pick_idx;
  logic             any_free;

  mshr_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
    .free(~vld_post), .idx(pick_idx), .any(any_free));

  // Named events
  rsp_kind_e          kind_now;
  logic               ev_insert, ev_refuse, ev_pf_dup, ev_partial, ev_overlap;
  logic               ev_retire, ev_wait;
  logic [STAMP_W-1:0] wait_amt, saved_amt;

  assign kind_now   = classify(match_any, alloc_is_pf, match_pf);
  assign ev_insert  = alloc_valid && !match_any && any_free;
  assign ev_refuse  = alloc_valid && !match_any && !any_free;
  assign ev_pf_dup  = alloc_valid && (kind_now == KIND_PF_DUP);
  assign ev_partial = alloc_valid && (kind_now == KIND_PARTIAL);
  assign ev_overlap = alloc_valid && (kind_now == KIND_OVERLAP);
  assign ev_retire  = |fill_kill;
  assign ev_wait    = wait_dem;
  assign wait_amt   = STAMP_W'(span(64'(now), 64'(wait_stamp), STAMP_W));
  assign saved_amt  = STAMP_W'(span(64'(now), 64'(match_stamp), STAMP_W));

  // Entry and response state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld     <= '0;
      ent_pf      <= '0;
      ent_line    <= '0;
      ent_stamp   <= '0;
      now         <= '0;
      rsp_valid   <= 1'b0;
      rsp_fresh   <= 1'b0;
      rsp_kind    <= 2'd0;
      rsp_refused <= 1'b0;
    end else begin
      now <= now + 1'b1;
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_kill[i]) ent_vld[i] <= 1'b0;
        if (ev_partial && alloc_match[i]) begin
          ent_pf[i]    <= 1'b0;
          ent_stamp[i] <= now;
        end
      end
      if (ev_insert) begin
        ent_vld[pick_idx]   <= 1'b1;
        ent_pf[pick_idx]    <= alloc_is_pf;
        ent_line[pick_idx]  <= alloc_line;
        ent_stamp[pick_idx] <= now;
      end
      rsp_valid   <= alloc_valid;
      rsp_fresh   <= alloc_valid && !match_any;
      rsp_kind    <= alloc_valid ? kind_now : KIND_MISS;
      rsp_refused <= ev_refuse;
    end
  end

  // Population count
  always_comb begin
    occupancy = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      occupancy = occupancy + OCC_W'(ent_vld[i]);
    end
  end

  mshr_stats #(.CNT_W(CNT_W), .ACC_W(ACC_W), .STAMP_W(STAMP_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .ev_refuse(ev_refuse), .ev_pf_dup(ev_pf_dup),
    .ev_partial(ev_partial), .ev_overlap(ev_overlap),
    .ev_wait(ev_wait), .wait_amt(wait_amt), .saved_amt(saved_amt),
    .cnt_full(cnt_full), .cnt_pf_dup(cnt_pf_dup),
    .cnt_partial(cnt_partial), .cnt_overlap(cnt_overlap),
    .acc_saved(acc_saved), .acc_waited(acc_waited));

endmodule

// File: rtl/mshr_table_chk.sv
`timescale 1ns/1ps
module mshr_table_chk #(
  parameter int ENTRIES = 16,
  parameter int OCC_W   = 5,
  parameter int CNT_W   = 32,
  parameter int ACC_W   = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input logic             rsp_valid,
  input logic             rsp_fresh,
  input logic [1:0]       rsp_kind,
  input logic             rsp_refused,
  input logic [OCC_W-1:0] occupancy,
  input logic [CNT_W-1:0] cnt_full,
  input logic [CNT_W-1:0] cnt_pf_dup,
  input logic [CNT_W-1:0] cnt_partial,
  input logic [CNT_W-1:0] cnt_overlap,
  input logic [ACC_W-1:0] acc_waited,
  input logic             ev_insert,
  input logic             ev_retire
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4
  refused_full_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (rsp_valid && rsp_refused) |-> (occupancy == OCC_W'(ENTRIES)));

  // R4
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (cnt_full != $past(cnt_full)) |-> (rsp_valid && rsp_refused && rsp_fresh));

  // R3
  dup_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (rsp_valid && !rsp_fresh) |-> (occupancy <= $past(occupancy)));

  // R2
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    occupancy <= OCC_W'($past(occupancy) + 1'b1));

  // R2
  insert_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_insert && !ev_retire) |=> (occupancy != '0));

  // R5
  pf_dup_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (rsp_valid && rsp_kind == 2'd1) |-> (cnt_pf_dup == CNT_W'($past(cnt_pf_dup) + 1'b1)));

  // R6
  partial_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (rsp_valid && rsp_kind == 2'd2) |-> (cnt_partial == CNT_W'($past(cnt_partial) + 1'b1)));

  // R7
  overlap_count_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (rsp_valid && rsp_kind == 2'd3) |-> (cnt_overlap == CNT_W'($past(cnt_overlap) + 1'b1)));

  // R8
  shrink_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (occupancy < $past(occupancy)) |-> $past(fill_valid));

  // R8
  waited_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (acc_waited != $past(acc_waited)) |-> $past(fill_valid));

endmodule

bind mshr_table mshr_table_chk #(
  .ENTRIES(ENTRIES), .OCC_W($clog2(ENTRIES+1)), .CNT_W(CNT_W), .ACC_W(ACC_W)
) u_mshr_table_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid),
  .rsp_valid(rsp_valid), .rsp_fresh(rsp_fresh), .rsp_kind(rsp_kind),
  .rsp_refused(rsp_refused), .occupancy(occupancy),
  .cnt_full(cnt_full), .cnt_pf_dup(cnt_pf_dup), .cnt_partial(cnt_partial),
  .cnt_overlap(cnt_overlap), .acc_waited(acc_waited),
  .ev_insert(ev_insert), .ev_retire(ev_retire));

// File: tb/test_mshr_table.sv
`timescale 1ns/1ps
module test_mshr_table;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 1'b0, alloc_valid = 1'b0, alloc_is_pf = 1'b0;
  logic [63:0] fill_addr = '0, alloc_addr = '0, lookup_addr = '0;
  logic        lookup_hit, rsp_valid, rsp_fresh, rsp_refused;
  logic [1:0]  rsp_kind;
  logic [4:0]  occupancy;
  logic [31:0] cnt_full, cnt_pf_dup, cnt_partial, cnt_overlap;
  logic [47:0] acc_saved, acc_waited;

  always #2 clk = ~clk;

  mshr_table i_mshr_table (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .alloc_valid(alloc_valid), .alloc_is_pf(alloc_is_pf), .alloc_addr(alloc_addr),
    .lookup_addr(lookup_addr), .lookup_hit(lookup_hit), .rsp_valid(rsp_valid),
    .rsp_fresh(rsp_fresh), .rsp_kind(rsp_kind), .rsp_refused(rsp_refused),
    .occupancy(occupancy), .cnt_full(cnt_full), .cnt_pf_dup(cnt_pf_dup),
    .cnt_partial(cnt_partial), .cnt_overlap(cnt_overlap),
    .acc_saved(acc_saved), .acc_waited(acc_waited));

  int checks = 0, failures = 0;
  bit done = 0;
  longint unsigned tb_now = 0;
  always @(posedge clk) if (rst_n) tb_now <= tb_now + 1;

  // Reference model
  bit              m_vld [N];
  bit              m_pf  [N];
  logic [57:0]     m_line[N];
  longint unsigned m_stamp[N];
  longint unsigned e_full = 0, e_pfd = 0, e_part = 0, e_ovl = 0, e_saved = 0, e_wait = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_find(input logic [57:0] ln);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_line[i] == ln) return i;
    return -1;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < N; i++) c += m_vld[i];
    return c;
  endfunction

  // One operation: called at a falling edge, returns at the next one.
  task automatic op(input bit fv, input logic [63:0] fa, input bit av,
                    input bit apf, input logic [63:0] aa);
    longint unsigned t;
    int idx, slot;
    bit  x_fresh, x_ref;
    logic [1:0] x_kind;
    fill_valid = fv; fill_addr = fa;
    alloc_valid = av; alloc_is_pf = apf; alloc_addr = aa;
    t = tb_now;
    if (fv) begin
      idx = m_find(fa[63:6]);
      if (idx >= 0) begin
        if (!m_pf[idx]) e_wait += t - m_stamp[idx];
        m_vld[idx] = 0;
      end
    end
    x_fresh = 0; x_ref = 0; x_kind = 0;
    if (av) begin
      idx = m_find(aa[63:6]);
      if (idx < 0) begin
        x_fresh = 1;
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        if (slot < 0) begin x_ref = 1; e_full++; end
        else begin
          m_vld[slot] = 1; m_pf[slot] = apf; m_line[slot] = aa[63:6]; m_stamp[slot] = t;
        end
      end else if (apf) begin
        x_kind = 1; e_pfd++;
      end else if (m_pf[idx]) begin
        x_kind = 2; e_part++; e_saved += t - m_stamp[idx];
        m_pf[idx] = 0; m_stamp[idx] = t;
      end else begin
        x_kind = 3; e_ovl++;
      end
    end
    @(negedge clk);
    fill_valid = 0; alloc_valid = 0;
    chk("R2 rsp_valid", 64'(rsp_valid), 64'(av));
    if (av) begin
      chk("R3 rsp_fresh", 64'(rsp_fresh), 64'(x_fresh));
      chk("R5 rsp_kind", 64'(rsp_kind), 64'(x_kind));
      chk("R4 rsp_refused", 64'(rsp_refused), 64'(x_ref));
    end
    chk("R2 occupancy", 64'(occupancy), 64'(m_count()));
    chk("R4 cnt_full", 64'(cnt_full), e_full);
    chk("R5 cnt_pf_dup", 64'(cnt_pf_dup), e_pfd);
    chk("R6 cnt_partial", 64'(cnt_partial), e_part);
    chk("R7 cnt_overlap", 64'(cnt_overlap), e_ovl);
    chk("R6 acc_saved", 64'(acc_saved), e_saved);
    chk("R8 acc_waited", 64'(acc_waited), e_wait);
  endtask

  task automatic lk(input logic [63:0] a, input bit exp, input string req);
    lookup_addr = a;
    #0.5;
    chk(req, 64'(lookup_hit), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] ln(input int i, input int low);
    return 64'h0000_0ABC_0000_0000 + 64'(i) * 64 + 64'(low & 63);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_pf[i] = 0; m_line[i] = 0; m_stamp[i] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 occupancy", 64'(occupancy), 0);
    chk("R10 rsp_valid", 64'(rsp_valid), 0);
    chk("R10 cnt_full", 64'(cnt_full), 0);
    chk("R10 acc_waited", 64'(acc_waited), 0);
    chk("R10 acc_saved", 64'(acc_saved), 0);
    rst_n = 1;
    lk(ln(0, 0), 0, "R10 lookup empty");

    // R2 / R1: fill the table with demand misses, varying low bits
    for (int i = 0; i < N; i++) op(0, 0, 1, 0, ln(i, i * 5));
    for (int i = 0; i < N; i++) lk(ln(i, 63 - i), 1, "R1 lookup low bits ignored");
    lk(ln(N, 0), 0, "R2 absent line misses");

    // R4: table full
    op(0, 0, 1, 0, ln(40, 0));
    op(0, 0, 1, 1, ln(41, 7));
    lk(ln(40, 0), 0, "R4 refused line not tracked");

    // R7 and R3: demand duplicate with other low bits
    op(0, 0, 1, 0, ln(3, 33));
    // R5: prefetch duplicate of a demand entry
    op(0, 0, 1, 1, ln(5, 1));

    // R9: fill and allocation together while full
    op(1, ln(2, 9), 1, 0, ln(42, 0));
    lk(ln(2, 0), 0, "R9 filled line retired");
    lk(ln(42, 0), 1, "R9 new line took freed slot");
    // R9: same line filled and re-requested
    op(1, ln(4, 0), 1, 0, ln(4, 17));
    lk(ln(4, 0), 1, "R9 refill re-tracked");

    // R8: fill of an absent line, then retire several with waits
    op(1, ln(50, 0), 0, 0, 0);
    idle(3);
    for (int i = 5; i < N; i++) begin op(1, ln(i, i), 0, 0, 0); idle(i % 3); end

    // R5 / R6: prefetches joined by demands after various delays
    op(0, 0, 1, 1, ln(60, 0));
    op(0, 0, 1, 1, ln(60, 2));
    idle(4);
    op(0, 0, 1, 0, ln(60, 3));
    op(0, 0, 1, 0, ln(60, 4));
    idle(2);
    op(1, ln(60, 0), 0, 0, 0);
    op(0, 0, 1, 1, ln(61, 0));
    idle(7);
    op(1, ln(61, 0), 0, 0, 0);
    lk(ln(61, 0), 0, "R8 prefetch entry retired");

    // Mixed sweep over a pool a little larger than the table
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      bit fv, av, pf;
      int fi, ai;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fv = lf[0] & lf[3];
      av = lf[1] | lf[5];
      pf = lf[2];
      fi = int'(lf[11:7]) % 22;
      ai = int'(lf[15:11]) % 22;
      op(fv, ln(100 + fi, int'(lf[5:0])), av, pf, ln(100 + ai, int'(lf[9:4])));
      if (k % 97 == 0) lk(ln(100 + ai, 11), m_find(ln(100 + ai, 0) >> 6) >= 0, "R1 sweep lookup");
    end
    summary();
  end
endmodule